// File: doc/BRIEF.md
# Delayed Read Request Tracker

This block sits on the target side of a bus bridge and handles reads from regions where reads have side effects, so data cannot be fetched ahead of time. An initiator presents a read as a one-cycle request carrying a command code, an address and a byte-enable vector. When the tracker is empty it captures that request, forwards it once to the local interconnect over a valid/ready handshake, and tells the initiator to retry. When the initiator later reissues the same read, it gets the data, marked as the last transfer.

The tracker holds exactly one request. Any other read that arrives while the entry is occupied is retried, and nothing about it is remembered. Response data from the local side is latched whenever it arrives. It is released only when every outbound posted write that was pending at capture time has completed. That way a read can never overtake a write that was issued before it.

Top module: `drt_tracker`

## Requirements
- R1: After reset, `term_valid` is 0 and `lcl_req_valid` is 0.
- R2: A request that arrives while the entry is empty yields a retry termination (`term_code` = 2'b01). The cycle after the request, `lcl_req_valid` is 1 and `lcl_req_cmd`/`lcl_req_addr`/`lcl_req_be` carry the request's fields.
- R3: `lcl_req_valid` and the forwarded fields stay unchanged until a cycle with `lcl_req_ready` = 1. After that cycle `lcl_req_valid` is 0.
- R4: While the entry is occupied, a request whose command, address or byte enables differ in any bit from the held entry is retried. The held entry is not changed: the original read still completes afterwards.
- R5: A matching request that arrives before response data has been latched is retried.
- R6: Response data is latched whenever `lcl_rsp_valid` is 1 while the entry is occupied, even when no request is present. A later matching request with no write barrier outstanding yields `term_code` = 2'b10 (data with disconnect) and `term_data` equal to the latched data. The entry then becomes empty, so the next request is captured and forwarded again.
- R7: At capture, a barrier count is loaded from `ow_pend_cnt`, less one if `ow_done` is high in that cycle. Each `ow_done` pulse decrements the count. A matching request with data is retried until the count is zero.
- R8: Each request cycle yields exactly one termination, with `term_valid` = 1 in the following cycle and 0 in the cycle after a non-request. `term_code` is never 2'b11 (target abort).
- R9: Changes to `ow_pend_cnt` after capture do not affect the barrier of the held read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Initiator read request strobe, one cycle per attempt |
| req_cmd | input | 4 | Read command code |
| req_addr | input | 32 | Read address |
| req_be | input | 4 | Byte enables |
| term_valid | output | 1 | Termination present, one cycle after a request |
| term_code | output | 2 | 2'b01 retry, 2'b10 data with disconnect |
| term_data | output | 32 | Read data accompanying a disconnect |
| lcl_req_valid | output | 1 | Forwarded read request valid |
| lcl_req_ready | input | 1 | Local side accepts the forwarded request |
| lcl_req_cmd | output | 4 | Forwarded command |
| lcl_req_addr | output | 32 | Forwarded address |
| lcl_req_be | output | 4 | Forwarded byte enables |
| lcl_rsp_valid | input | 1 | Local response data valid |
| lcl_rsp_data | input | 32 | Local response data |
| ow_pend_cnt | input | 4 | Outbound posted writes currently pending |
| ow_done | input | 1 | Pulse: one outbound posted write completed |

## Verification
The hardest case to reach is a held read whose data has already arrived but is still blocked by the write barrier. It also has to be shown that later increases in the pending-write count do not extend that barrier. The stimulus captures a read while two writes are reported pending, then raises the pending count, and only then lets the local side accept the request and return data. It then reissues the matching read after each individual write-complete pulse, expecting retries until the second pulse and a disconnect with the stored data after it. Mismatching reads, each differing in only one field, are interleaved while data is held, to show they neither take the data nor disturb the entry.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    TERM_NONE  = 2'b00,
    TERM_RETRY = 2'b01,
    TERM_DISC  = 2'b10
  } term_e;
endpackage

// File: rtl/drt_entry.sv
// Single held read request: capture, compare, and forward handshake.
module drt_entry #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr_en,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic              fwd_ready,
  output logic              full,
  output logic              hit,
  output logic              fwd_valid,
  output logic [CMD_W-1:0]  held_cmd,
  output logic [ADDR_W-1:0] held_addr,
  output logic [BE_W-1:0]   held_be
);
  logic full_d, fwd_d;

  always_comb begin
    full_d = full;
    fwd_d  = fwd_valid;
    if (cap_en) begin
      full_d = 1'b1;
      fwd_d  = 1'b1;
    end else begin
      if (clr_en)                 full_d = 1'b0;
      if (fwd_valid && fwd_ready) fwd_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      fwd_valid <= 1'b0;
    end else begin
      full      <= full_d;
      fwd_valid <= fwd_d;
    end
  end

  // Field registers: clock enable only, no reset needed.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      held_cmd  <= in_cmd;
      held_addr <= in_addr;
      held_be   <= in_be;
    end
  end

  assign hit = full && (in_cmd == held_cmd) && (in_addr == held_addr)
                    && (in_be == held_be);
endmodule

// File: rtl/drt_gate.sv
// Response data latch and outbound-write ordering barrier.
module drt_gate #(
  parameter int DATA_W = 32,
  parameter int WCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr_en,
  input  logic              full,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [WCNT_W-1:0] pend_cnt,
  input  logic              wr_done,
  output logic              data_vld,
  output logic [DATA_W-1:0] data_q,
  output logic [WCNT_W-1:0] bar_cnt,
  output logic              bar_zero
);
  localparam logic [WCNT_W-1:0] CNT_ONE  = {{(WCNT_W-1){1'b0}}, 1'b1};
  localparam logic [WCNT_W-1:0] CNT_ZERO = '0;

  logic              vld_d;
  logic              data_ld;
  logic [WCNT_W-1:0] bar_d;

  assign data_ld = full && !data_vld && rsp_valid;

  always_comb begin
    vld_d = data_vld;
    if (clr_en)       vld_d = 1'b0;
    else if (data_ld) vld_d = 1'b1;
  end

  always_comb begin
    bar_d = bar_cnt;
    if (cap_en) begin
      if (wr_done && pend_cnt != CNT_ZERO) bar_d = pend_cnt - CNT_ONE;
      else                                 bar_d = pend_cnt;
    end else if (wr_done && bar_cnt != CNT_ZERO) begin
      bar_d = bar_cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_vld <= 1'b0;
      bar_cnt  <= CNT_ZERO;
    end else begin
      data_vld <= vld_d;
      bar_cnt  <= bar_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_ld) data_q <= rsp_data;
  end

  assign bar_zero = (bar_cnt == CNT_ZERO);
endmodule

// File: rtl/drt_tracker.sv
module drt_tracker #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int DATA_W = 32,
  parameter int WCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic              term_valid,
  output logic [1:0]        term_code,
  output logic [DATA_W-1:0] term_data,
  output logic              lcl_req_valid,
  input  logic              lcl_req_ready,
  output logic [CMD_W-1:0]  lcl_req_cmd,
  output logic [ADDR_W-1:0] lcl_req_addr,
  output logic [BE_W-1:0]   lcl_req_be,
  input  logic              lcl_rsp_valid,
  input  logic [DATA_W-1:0] lcl_rsp_data,
  input  logic [WCNT_W-1:0] ow_pend_cnt,
  input  logic              ow_done
);
  import drt_pkg::*;

  logic              full, hit, data_vld, bar_zero;
  logic [DATA_W-1:0] data_q;
  logic [WCNT_W-1:0] bar_cnt;
  logic              cap_en, deliver;
  term_e             code_d;

  assign cap_en  = req_valid && !full;
  assign deliver = req_valid && hit && data_vld && bar_zero;

  drt_entry #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .clr_en(deliver),
    .in_cmd(req_cmd), .in_addr(req_addr), .in_be(req_be),
    .fwd_ready(lcl_req_ready), .full(full), .hit(hit),
    .fwd_valid(lcl_req_valid), .held_cmd(lcl_req_cmd),
    .held_addr(lcl_req_addr), .held_be(lcl_req_be)
  );

  drt_gate #(.DATA_W(DATA_W), .WCNT_W(WCNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .clr_en(deliver),
    .full(full), .rsp_valid(lcl_rsp_valid), .rsp_data(lcl_rsp_data),
    .pend_cnt(ow_pend_cnt), .wr_done(ow_done), .data_vld(data_vld),
    .data_q(data_q), .bar_cnt(bar_cnt), .bar_zero(bar_zero)
  );

  always_comb begin
    code_d = TERM_NONE;
    if (req_valid) code_d = deliver ? TERM_DISC : TERM_RETRY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_valid <= 1'b0;
      term_code  <= TERM_NONE;
    end else begin
      term_valid <= req_valid;
      term_code  <= code_d;
    end
  end

  always_ff @(posedge clk) begin
    if (deliver) term_data <= data_q;
  end
endmodule

// File: rtl/drt_tracker_chk.sv
module drt_tracker_chk #(
  parameter int ADDR_W = 32,
  parameter int WCNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              term_valid,
  input logic [1:0]        term_code,
  input logic              lcl_req_valid,
  input logic              lcl_req_ready,
  input logic [ADDR_W-1:0] lcl_req_addr,
  input logic              full,
  input logic [WCNT_W-1:0] bar_cnt
);
  // R8: one termination per request cycle
  p_one_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> term_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !term_valid);
  p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (term_code == 2'b01 || term_code == 2'b10));
  // R2: empty entry captures, retries and forwards
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !full) |=> (term_code == 2'b01 && lcl_req_valid && full));
  // R3: forwarded request held until accepted
  p_hold_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_req_valid && !lcl_req_ready) |=> (lcl_req_valid && $stable(lcl_req_addr)));
  // R6: a disconnect leaves the entry empty
  p_disc_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && term_code == 2'b10) |-> !full);
  // R7: no release while the barrier is open
  p_barrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bar_cnt != '0) |=> term_code != 2'b10);
endmodule

bind drt_tracker drt_tracker_chk #(.ADDR_W(ADDR_W), .WCNT_W(WCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .term_valid(term_valid),
  .term_code(term_code), .lcl_req_valid(lcl_req_valid),
  .lcl_req_ready(lcl_req_ready), .lcl_req_addr(lcl_req_addr),
  .full(full), .bar_cnt(bar_cnt)
);

// File: tb/sim_drt_tracker.sv
`timescale 1ns/1ps
module sim_drt_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        term_valid;
  logic [1:0]  term_code;
  logic [31:0] term_data;
  logic        lcl_req_valid;
  logic        lcl_req_ready = 1'b0;
  logic [3:0]  lcl_req_cmd;
  logic [31:0] lcl_req_addr;
  logic [3:0]  lcl_req_be;
  logic        lcl_rsp_valid = 1'b0;
  logic [31:0] lcl_rsp_data = '0;
  logic [3:0]  ow_pend_cnt = '0;
  logic        ow_done = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [1:0] RETRY = 2'b01;
  localparam logic [1:0] DISC  = 2'b10;

  always #2 clk = ~clk;

  drt_tracker u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a negedge, sample termination at the next negedge.
  task automatic send(input logic [3:0] c, input logic [31:0] a,
                      input logic [3:0] b, output logic [1:0] code,
                      output logic [31:0] data);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_be = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(term_valid == 1'b1, "R8 term_valid after request", {31'b0, term_valid}, 32'd1);
    code = term_code;
    data = term_data;
    @(negedge clk);
    chk(term_valid == 1'b0, "R8 term_valid idle", {31'b0, term_valid}, 32'd0);
  endtask

  task automatic accept();
    lcl_req_ready = 1'b1;
    @(negedge clk);
    lcl_req_ready = 1'b0;
  endtask

  task automatic respond(input logic [31:0] d);
    lcl_rsp_valid = 1'b1; lcl_rsp_data = d;
    @(negedge clk);
    lcl_rsp_valid = 1'b0;
  endtask

  task automatic pulse_done();
    ow_done = 1'b1;
    @(negedge clk);
    ow_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(term_valid == 1'b0, "R1 term_valid", {31'b0, term_valid}, 32'd0);
    chk(lcl_req_valid == 1'b0, "R1 lcl_req_valid", {31'b0, lcl_req_valid}, 32'd0);
  endtask

  task automatic t_capture();
    logic [1:0] c; logic [31:0] d;
    send(4'h6, 32'h1000_0040, 4'hF, c, d);
    chk(c == RETRY, "R2 first read retried", {30'b0, c}, {30'b0, RETRY});
    chk(lcl_req_valid == 1'b1, "R2 forwarded", {31'b0, lcl_req_valid}, 32'd1);
    chk(lcl_req_addr == 32'h1000_0040, "R2 fwd addr", lcl_req_addr, 32'h1000_0040);
    chk(lcl_req_cmd == 4'h6 && lcl_req_be == 4'hF, "R2 fwd cmd/be",
        {24'b0, lcl_req_cmd, lcl_req_be}, 32'h6F);
    repeat (3) @(negedge clk);
    chk(lcl_req_valid == 1'b1 && lcl_req_addr == 32'h1000_0040, "R3 held while not ready",
        lcl_req_addr, 32'h1000_0040);
    accept();
    chk(lcl_req_valid == 1'b0, "R3 dropped after handshake", {31'b0, lcl_req_valid}, 32'd0);
  endtask

  task automatic t_match_deliver();
    logic [1:0] c; logic [31:0] d;
    send(4'h6, 32'h1000_0040, 4'hF, c, d);
    chk(c == RETRY, "R5 match without data", {30'b0, c}, {30'b0, RETRY});
    send(4'h6, 32'h1000_0040, 4'h3, c, d);
    chk(c == RETRY, "R4 be mismatch", {30'b0, c}, {30'b0, RETRY});
    respond(32'hCAFE_0001);
    repeat (2) @(negedge clk);
    send(4'h6, 32'h1000_0044, 4'hF, c, d);
    chk(c == RETRY, "R4 addr mismatch with data held", {30'b0, c}, {30'b0, RETRY});
    send(4'h7, 32'h1000_0040, 4'hF, c, d);
    chk(c == RETRY, "R4 cmd mismatch", {30'b0, c}, {30'b0, RETRY});
    chk(lcl_req_valid == 1'b0, "R4 no new forward", {31'b0, lcl_req_valid}, 32'd0);
    send(4'h6, 32'h1000_0040, 4'hF, c, d);
    chk(c == DISC, "R6 delivered", {30'b0, c}, {30'b0, DISC});
    chk(d == 32'hCAFE_0001, "R6 data", d, 32'hCAFE_0001);
    // Entry now empty: the earlier mismatching read is a new request.
    send(4'h6, 32'h1000_0044, 4'hF, c, d);
    chk(c == RETRY, "R6 new capture retried", {30'b0, c}, {30'b0, RETRY});
    chk(lcl_req_valid == 1'b1 && lcl_req_addr == 32'h1000_0044, "R6 new forward",
        lcl_req_addr, 32'h1000_0044);
    accept();
    respond(32'hCAFE_0002);
    send(4'h6, 32'h1000_0044, 4'hF, c, d);
    chk(c == DISC && d == 32'hCAFE_0002, "R6 second delivery", d, 32'hCAFE_0002);
  endtask

  task automatic t_order();
    logic [1:0] c; logic [31:0] d;
    ow_pend_cnt = 4'd2;
    send(4'hA, 32'h2000_0000, 4'h1, c, d);
    chk(c == RETRY, "R7 capture with writes pending", {30'b0, c}, {30'b0, RETRY});
    ow_pend_cnt = 4'd7;  // later posts must not extend the barrier (R9)
    accept();
    respond(32'hBEEF_0003);
    send(4'hA, 32'h2000_0000, 4'h1, c, d);
    chk(c == RETRY, "R7 data held behind two writes", {30'b0, c}, {30'b0, RETRY});
    pulse_done();
    send(4'hA, 32'h2000_0000, 4'h1, c, d);
    chk(c == RETRY, "R7 still one write open", {30'b0, c}, {30'b0, RETRY});
    pulse_done();
    send(4'hA, 32'h2000_0000, 4'h1, c, d);
    chk(c == DISC, "R9 released despite later posts", {30'b0, c}, {30'b0, DISC});
    chk(d == 32'hBEEF_0003, "R7 data after barrier", d, 32'hBEEF_0003);
    ow_pend_cnt = 4'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_capture();
    t_match_deliver();
    t_order();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule